// File: doc/BRIEF.md
# Triggered Multichannel Scan Sequencer

This block paces a multichannel analog-to-digital acquisition from a single timebase clock. A scan-period counter issues a scan strobe, and within each scan a channel-spacing counter issues one conversion strobe per channel, together with the channel index. The scan-busy level can hold an external sample-and-hold for the duration of a scan. A store qualifier marks the conversions that downstream storage must keep.

Four capture modes decide how a single trigger pulse shapes the run. The post and delayed modes wait for the trigger and then capture a fixed number of scans, and they can re-arm for a programmed number of triggers. The pre and middle modes scan from start into a rolling window of the last M scans, and the trigger ends or splits that window. A scan that is running when the trigger is accepted always completes. The block has no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status level or pulse. Configuration inputs must stay stable while a run is active.

Top module: `trig_scan_seq`

## Requirements
- R1: A start pulse in idle is refused, leaving `acq_busy` low and setting `cfg_err` from the next cycle, when `scan_ivl` < `smp_ivl` × `num_chan` or when any of the three is zero. A valid start clears `cfg_err`.
- R2: While scanning, `scan_start` pulses every `scan_ivl` cycles. Conversion k of a scan (k = 0 .. `num_chan`-1) pulses `conv` exactly k × `smp_ivl` cycles after `scan_start`, with `chan_idx` = k. `store_en` accompanies every conversion.
- R3: `scan_busy` is high from the `scan_start` cycle through the cycle of the scan's last conversion, inclusive.
- R4: In post mode (`mode` = 0), after start the block waits for `trig`. The first `scan_start` comes in the cycle after the cycle in which `trig` is high. It then captures `post_scans` scans, where 0 counts as 1.
- R5: With `retrig_cnt` = R (0 counts as 1), the post and delayed modes re-arm after each capture and end after R triggers, giving `num_chan` × `post_scans` × R conversions. Triggers during a capture are ignored.
- R6: In delayed mode (`mode` = 1), a trigger loads `delay_cnt` = D into a down-counter. The first `scan_start` comes D + 2 cycles after the trigger cycle.
- R7: In pre mode (`mode` = 2), scanning starts in the cycle after start. `buf_scans` counts completed scans, saturating at `pre_scans`, and holds its value after the run. A trigger accepted between scans ends the run in the next cycle, so fewer than `pre_scans` scans remain if it comes early.
- R8: In pre and middle modes, a trigger accepted while `scan_busy` is high lets that scan finish, and the scan counts as a pre-trigger scan.
- R9: With `m_enable` high, a trigger in pre or middle mode is ignored while `buf_scans` < `pre_scans`.
- R10: In middle mode (`mode` = 3), after the accepted trigger and the scan it may interrupt, exactly `post_scans` further scans run and then the run ends.
- R11: A `stop` pulse forces idle at the next edge. From then on there is no further conversion, and `acq_busy` and `scan_busy` are low.
- R12: `acq_busy` is high from the cycle after an accepted start until the cycle after the run's last conversion. It stays high while waiting for a trigger or a delay. `scan_busy` is never high while `acq_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured in idle only |
| stop | input | 1 | Abort pulse, overrides start |
| trig | input | 1 | Trigger pulse from the selected source |
| mode | input | 2 | 0 post, 1 delayed, 2 pre, 3 middle |
| m_enable | input | 1 | Ignore triggers until the pre window is full |
| scan_ivl | input | SI_W | Scan period in timebase cycles |
| smp_ivl | input | SMP_W | Channel spacing in timebase cycles |
| num_chan | input | CH_W+1 | Channels per scan |
| pre_scans | input | M_W | Pre-trigger window M |
| post_scans | input | N_W | Scans after a trigger N |
| retrig_cnt | input | RT_W | Number of triggers in post and delayed modes |
| delay_cnt | input | DLY_W | Trigger-to-scan delay in cycles |
| scan_start | output | 1 | First-conversion strobe of a scan |
| conv | output | 1 | Conversion strobe |
| store_en | output | 1 | Conversion must be kept |
| chan_idx | output | CH_W | Channel of the current conversion |
| scan_busy | output | 1 | Scan in progress (sample-and-hold gate) |
| acq_busy | output | 1 | Acquisition run active |
| cfg_err | output | 1 | Last start refused for bad timing |
| buf_scans | output | M_W | Valid scans in the pre-trigger window |

## Verification
On every cycle, the assertions check that a channel index stays below the channel count and that a scan's busy window closes only after its last conversion. They also check that nothing converts while the block waits for a trigger or a delay, that stop and a refused start leave the block idle, and that the window count never exceeds M. Only the directed scenarios can show when the behaviour happens. They measure the trigger-to-first-scan latency in each mode, the total conversions under re-trigger and middle capture, the shortened window after an early trigger, and the dropping of a trigger while the window fills.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    MODE_POST  = 2'd0,
    MODE_DELAY = 2'd1,
    MODE_PRE   = 2'd2,
    MODE_MID   = 2'd3
  } trig_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_WAIT = 3'd2,
    ST_CAPT = 3'd3,
    ST_PRE  = 3'd4,
    ST_TAIL = 3'd5
  } seq_state_e;
endpackage

// File: rtl/seq_cfg_check.sv
module seq_cfg_check #(
  parameter int SI_W  = 24,
  parameter int SMP_W = 16,
  parameter int CH_W  = 6
) (
  input  logic [SI_W-1:0]  scan_ivl,
  input  logic [SMP_W-1:0] smp_ivl,
  input  logic [CH_W:0]    nch,
  output logic             cfg_bad
);
  localparam int PW = SMP_W + CH_W + 1;
  localparam int CW = (SI_W > PW) ? SI_W : PW;

  logic [CW-1:0] span;
  logic [CW-1:0] need;

  always_comb begin
    span    = CW'(scan_ivl);
    need    = CW'(smp_ivl) * CW'(nch);
    cfg_bad = (scan_ivl == '0) || (smp_ivl == '0) || (nch == '0) || (span < need);
  end
endmodule

// File: rtl/seq_scan_timer.sv
module seq_scan_timer #(
  parameter int SI_W  = 24,
  parameter int SMP_W = 16,
  parameter int CH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SI_W-1:0]  scan_ivl,
  input  logic [SMP_W-1:0] smp_ivl,
  input  logic [CH_W:0]    nch,
  output logic             scan_start,
  output logic             conv,
  output logic [CH_W-1:0]  chan_idx,
  output logic             scan_busy,
  output logic             last_conv
);
  logic [SI_W-1:0]  si_cnt;
  logic [SMP_W-1:0] sub_cnt;
  logic [CH_W:0]    nxt_ch;
  logic             in_scan;
  logic             mid_conv;
  logic [CH_W:0]    idx_w;

  always_comb begin
    scan_start = run && (si_cnt == '0);
    mid_conv   = run && in_scan && (sub_cnt == smp_ivl);
    conv       = scan_start || mid_conv;
    idx_w      = scan_start ? '0 : nxt_ch;
    chan_idx   = idx_w[CH_W-1:0];
    last_conv  = conv && (idx_w == nch - 1'b1);
    scan_busy  = scan_start || (run && in_scan);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_cnt  <= '0;
      sub_cnt <= '0;
      nxt_ch  <= '0;
      in_scan <= 1'b0;
    end else if (!run) begin
      si_cnt  <= '0;
      sub_cnt <= '0;
      nxt_ch  <= '0;
      in_scan <= 1'b0;
    end else begin
      si_cnt <= (si_cnt == scan_ivl - 1'b1) ? '0 : si_cnt + 1'b1;
      if (scan_start) begin
        nxt_ch  <= {{CH_W{1'b0}}, 1'b1};
        sub_cnt <= {{(SMP_W-1){1'b0}}, 1'b1};
        in_scan <= !last_conv;
      end else if (in_scan) begin
        if (mid_conv) begin
          nxt_ch  <= nxt_ch + 1'b1;
          sub_cnt <= {{(SMP_W-1){1'b0}}, 1'b1};
          if (last_conv) in_scan <= 1'b0;
        end else begin
          sub_cnt <= sub_cnt + 1'b1;
        end
      end
    end
  end

  // R2: a conversion never names a channel beyond the scan width
  p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> ({1'b0, chan_idx} < nch));

  // R3: the busy window only closes after the scan's last conversion
  p_busy_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scan_busy) && run) |-> $past(last_conv));
endmodule

// File: rtl/seq_delay.sv
module seq_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             active,
  output logic             is_zero
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= load_val;
    else if (active && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);
endmodule

// File: rtl/trig_scan_seq.sv
module trig_scan_seq
  import seq_pkg::*;
#(
  parameter int SI_W  = 24,
  parameter int SMP_W = 16,
  parameter int CH_W  = 6,
  parameter int M_W   = 16,
  parameter int N_W   = 16,
  parameter int RT_W  = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             trig,
  input  logic [1:0]       mode,
  input  logic             m_enable,
  input  logic [SI_W-1:0]  scan_ivl,
  input  logic [SMP_W-1:0] smp_ivl,
  input  logic [CH_W:0]    num_chan,
  input  logic [M_W-1:0]   pre_scans,
  input  logic [N_W-1:0]   post_scans,
  input  logic [RT_W-1:0]  retrig_cnt,
  input  logic [DLY_W-1:0] delay_cnt,
  output logic             scan_start,
  output logic             conv,
  output logic             store_en,
  output logic [CH_W-1:0]  chan_idx,
  output logic             scan_busy,
  output logic             acq_busy,
  output logic             cfg_err,
  output logic [M_W-1:0]   buf_scans
);
  trig_mode_e  mode_e;
  seq_state_e  state;
  logic        pend;
  logic [N_W-1:0]  post_cnt;
  logic [RT_W-1:0] rt_cnt;
  logic [M_W-1:0]  buf_q;
  logic        cfg_err_q;

  logic        cfg_bad;
  logic        run;
  logic        last_conv;
  logic        dly_zero;
  logic        dly_load;
  logic [N_W-1:0]  n_eff;
  logic [RT_W-1:0] r_eff;
  logic        trig_ok;
  logic [M_W-1:0]  buf_inc;
  logic        to_tail;

  always_comb begin
    mode_e   = trig_mode_e'(mode);
    run      = (state == ST_CAPT) || (state == ST_PRE) || (state == ST_TAIL);
    n_eff    = (post_scans == '0) ? {{(N_W-1){1'b0}}, 1'b1} : post_scans;
    r_eff    = (retrig_cnt == '0) ? {{(RT_W-1){1'b0}}, 1'b1} : retrig_cnt;
    trig_ok  = trig && !(m_enable && (buf_q < pre_scans));
    buf_inc  = (buf_q < pre_scans) ? buf_q + 1'b1 : buf_q;
    to_tail  = (mode_e == MODE_MID) && (post_scans != '0);
    dly_load = (state == ST_ARM) && trig && (mode_e == MODE_DELAY);
  end

  seq_cfg_check #(.SI_W(SI_W), .SMP_W(SMP_W), .CH_W(CH_W)) u_cfg (
    .scan_ivl (scan_ivl),
    .smp_ivl  (smp_ivl),
    .nch      (num_chan),
    .cfg_bad  (cfg_bad)
  );

  seq_scan_timer #(.SI_W(SI_W), .SMP_W(SMP_W), .CH_W(CH_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .scan_ivl   (scan_ivl),
    .smp_ivl    (smp_ivl),
    .nch        (num_chan),
    .scan_start (scan_start),
    .conv       (conv),
    .chan_idx   (chan_idx),
    .scan_busy  (scan_busy),
    .last_conv  (last_conv)
  );

  seq_delay #(.DLY_W(DLY_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (delay_cnt),
    .active   (state == ST_WAIT),
    .is_zero  (dly_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend      <= 1'b0;
      post_cnt  <= '0;
      rt_cnt    <= '0;
      buf_q     <= '0;
      cfg_err_q <= 1'b0;
    end else if (stop) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cfg_err_q <= cfg_bad;
            if (!cfg_bad) begin
              post_cnt <= '0;
              rt_cnt   <= '0;
              buf_q    <= '0;
              pend     <= 1'b0;
              state    <= (mode_e == MODE_POST || mode_e == MODE_DELAY) ? ST_ARM : ST_PRE;
            end
          end
        end
        ST_ARM: begin
          if (trig) state <= (mode_e == MODE_DELAY) ? ST_WAIT : ST_CAPT;
        end
        ST_WAIT: begin
          if (dly_zero) state <= ST_CAPT;
        end
        ST_CAPT: begin
          if (last_conv) begin
            if (post_cnt == n_eff - 1'b1) begin
              post_cnt <= '0;
              if (rt_cnt == r_eff - 1'b1) begin
                state <= ST_IDLE;
              end else begin
                rt_cnt <= rt_cnt + 1'b1;
                state  <= ST_ARM;
              end
            end else begin
              post_cnt <= post_cnt + 1'b1;
            end
          end
        end
        ST_PRE: begin
          if (last_conv) begin
            buf_q <= buf_inc;
            if (pend || trig_ok) begin
              pend     <= 1'b0;
              post_cnt <= '0;
              state    <= to_tail ? ST_TAIL : ST_IDLE;
            end
          end else if (trig_ok) begin
            if (scan_busy) begin
              pend <= 1'b1;
            end else begin
              post_cnt <= '0;
              state    <= to_tail ? ST_TAIL : ST_IDLE;
            end
          end
        end
        ST_TAIL: begin
          if (last_conv) begin
            if (post_cnt == post_scans - 1'b1) state <= ST_IDLE;
            else post_cnt <= post_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign acq_busy  = (state != ST_IDLE);
  assign store_en  = conv && run;
  assign cfg_err   = cfg_err_q;
  assign buf_scans = buf_q;

  // R11: abort takes effect at the next edge
  p_stop_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!acq_busy && !conv && !scan_busy));

  // R1: a start with bad timing leaves the block idle and flagged
  p_refuse_bad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && !acq_busy && cfg_bad) |=> (!acq_busy && cfg_err));

  // R6: nothing converts while armed or counting the delay
  p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ARM) || (state == ST_WAIT)) |-> !conv);

  // R7: the window count never exceeds M during a run
  p_window_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acq_busy |-> (buf_scans <= pre_scans));

  // R12: no scan activity outside a run
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_busy |-> (!scan_busy && !store_en));
endmodule

// File: tb/test_trig_scan_seq.sv
module test_trig_scan_seq;
  localparam int SI_W  = 24;
  localparam int SMP_W = 16;
  localparam int CH_W  = 6;
  localparam int M_W   = 16;
  localparam int N_W   = 16;
  localparam int RT_W  = 8;
  localparam int DLY_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start, stop, trig, m_enable;
  logic [1:0] mode;
  logic [SI_W-1:0]  scan_ivl;
  logic [SMP_W-1:0] smp_ivl;
  logic [CH_W:0]    num_chan;
  logic [M_W-1:0]   pre_scans;
  logic [N_W-1:0]   post_scans;
  logic [RT_W-1:0]  retrig_cnt;
  logic [DLY_W-1:0] delay_cnt;
  logic scan_start, conv, store_en, scan_busy, acq_busy, cfg_err;
  logic [CH_W-1:0] chan_idx;
  logic [M_W-1:0]  buf_scans;

  always #10 clk = ~clk;

  trig_scan_seq #(.SI_W(SI_W), .SMP_W(SMP_W), .CH_W(CH_W), .M_W(M_W),
                  .N_W(N_W), .RT_W(RT_W), .DLY_W(DLY_W)) i_trig_scan_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .trig(trig),
    .mode(mode), .m_enable(m_enable), .scan_ivl(scan_ivl), .smp_ivl(smp_ivl),
    .num_chan(num_chan), .pre_scans(pre_scans), .post_scans(post_scans),
    .retrig_cnt(retrig_cnt), .delay_cnt(delay_cnt), .scan_start(scan_start),
    .conv(conv), .store_en(store_en), .chan_idx(chan_idx), .scan_busy(scan_busy),
    .acq_busy(acq_busy), .cfg_err(cfg_err), .buf_scans(buf_scans)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int n_ss, n_conv, n_store, n_busy, first_ss, last_ss, last_acq, idx_err, si2_b;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_start) begin
        n_ss = n_ss + 1;
        if (first_ss < 0) first_ss = cyc;
        last_ss = cyc;
      end
      if (conv) begin
        n_conv = n_conv + 1;
        if (int'(chan_idx) != (cyc - last_ss) / si2_b) idx_err = idx_err + 1;
      end
      if (store_en)  n_store = n_store + 1;
      if (scan_busy) n_busy  = n_busy + 1;
      if (acq_busy)  last_acq = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic clr_mon();
    @(posedge clk);
    n_ss = 0; n_conv = 0; n_store = 0; n_busy = 0;
    first_ss = -1; last_ss = 0; last_acq = -1; idx_err = 0;
  endtask

  task automatic set_cfg(input int md, input int si, input int si2, input int nch,
                         input int m, input int n, input int r, input int d, input bit men);
    @(negedge clk);
    mode       = 2'(md);
    scan_ivl   = SI_W'(si);
    smp_ivl    = SMP_W'(si2);
    num_chan   = (CH_W+1)'(nch);
    pre_scans  = M_W'(m);
    post_scans = N_W'(n);
    retrig_cnt = RT_W'(r);
    delay_cnt  = DLY_W'(d);
    m_enable   = men;
    si2_b      = (si2 == 0) ? 1 : si2;
  endtask

  // start high during the returned cycle
  task automatic do_start(output int c);
    @(negedge clk);
    start = 1'b1; c = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic trig_in(input int c);
    @(negedge clk);
    while (cyc < c) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic stop_in(input int c);
    @(negedge clk);
    while (cyc < c) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (acq_busy && guard < 3000) begin
      @(negedge clk);
      guard = guard + 1;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 0; stop = 0; trig = 0;
    set_cfg(0, 10, 3, 3, 2, 1, 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R12", "reset acq_busy", int'(acq_busy), 0);
    chk_eq("R3",  "reset scan_busy", int'(scan_busy), 0);
    chk_eq("R2",  "reset conv", int'(conv), 0);
    chk_eq("R1",  "reset cfg_err", int'(cfg_err), 0);
    chk_eq("R7",  "reset buf_scans", int'(buf_scans), 0);
  endtask

  task automatic t_cfg();
    int c;
    set_cfg(2, 7, 2, 4, 2, 1, 1, 0, 0);
    do_start(c);
    repeat (3) @(negedge clk);
    chk_eq("R1", "bad cfg flags error", int'(cfg_err), 1);
    chk_eq("R1", "bad cfg stays idle", int'(acq_busy), 0);
    set_cfg(2, 8, 2, 4, 2, 1, 1, 0, 0);
    do_start(c);
    repeat (2) @(negedge clk);
    chk_eq("R1", "valid start clears error", int'(cfg_err), 0);
    chk_eq("R12", "valid start runs", int'(acq_busy), 1);
    stop_in(cyc + 1);
    wait_idle();
  endtask

  task automatic t_post();
    int c, tc;
    set_cfg(0, 10, 3, 3, 2, 2, 1, 0, 0);
    clr_mon();
    do_start(c);
    tc = c + 4;
    trig_in(tc);
    wait_idle();
    chk_eq("R4", "post first scan", first_ss, tc + 1);
    chk_eq("R4", "post scan count", n_ss, 2);
    chk_eq("R2", "post second scan spacing", last_ss, tc + 11);
    chk_eq("R2", "post conversions", n_conv, 6);
    chk_eq("R2", "post stored", n_store, 6);
    chk_eq("R2", "channel index errors", idx_err, 0);
    chk_eq("R3", "scan_busy cycles", n_busy, 14);
    chk_eq("R12", "post last busy cycle", last_acq, tc + 17);
  endtask

  task automatic t_retrig();
    int c, c1;
    set_cfg(0, 4, 2, 2, 2, 1, 3, 0, 0);
    clr_mon();
    do_start(c);
    c1 = c + 4;
    trig_in(c1);
    trig_in(c1 + 2);
    trig_in(c1 + 10);
    trig_in(c1 + 20);
    wait_idle();
    chk_eq("R5", "retrigger conversions", n_conv, 6);
    chk_eq("R5", "retrigger scans", n_ss, 3);
    chk_eq("R5", "retrigger end", last_acq, c1 + 23);
  endtask

  task automatic t_delay();
    int c, tc;
    set_cfg(1, 3, 1, 1, 2, 1, 1, 5, 0);
    clr_mon();
    do_start(c);
    tc = c + 3;
    trig_in(tc);
    wait_idle();
    chk_eq("R6", "delay 5 first scan", first_ss, tc + 7);
    chk_eq("R6", "delay 5 conversions", n_conv, 1);
    set_cfg(1, 3, 1, 1, 2, 1, 1, 0, 0);
    clr_mon();
    do_start(c);
    tc = c + 3;
    trig_in(tc);
    wait_idle();
    chk_eq("R6", "delay 0 first scan", first_ss, tc + 2);
  endtask

  task automatic t_pre_late();
    int c, s;
    set_cfg(2, 6, 2, 2, 3, 1, 1, 0, 0);
    clr_mon();
    do_start(c);
    s = c + 1;
    trig_in(s + 28);
    wait_idle();
    chk_eq("R7", "pre first scan after start", first_ss, s);
    chk_eq("R7", "pre conversions", n_conv, 10);
    chk_eq("R7", "pre window saturates", int'(buf_scans), 3);
    chk_eq("R7", "pre ends after idle trigger", last_acq, s + 28);
  endtask

  task automatic t_pre_early();
    int c, s;
    set_cfg(2, 6, 2, 2, 3, 1, 1, 0, 0);
    clr_mon();
    do_start(c);
    s = c + 1;
    trig_in(s + 7);
    wait_idle();
    chk_eq("R8", "in-progress scan finishes", n_conv, 4);
    chk_eq("R8", "finished scan counted", int'(buf_scans), 2);
    chk_eq("R8", "end after scan", last_acq, s + 8);
  endtask

  task automatic t_menable();
    int c, s;
    set_cfg(2, 6, 2, 2, 3, 1, 1, 0, 1);
    clr_mon();
    do_start(c);
    s = c + 1;
    trig_in(s + 3);
    trig_in(s + 20);
    wait_idle();
    chk_eq("R9", "early trigger ignored", n_conv, 8);
    chk_eq("R9", "later trigger ends run", last_acq, s + 20);
  endtask

  task automatic t_mid();
    int c, s;
    set_cfg(3, 6, 2, 2, 2, 2, 1, 0, 0);
    clr_mon();
    do_start(c);
    s = c + 1;
    trig_in(s + 13);
    wait_idle();
    chk_eq("R10", "middle conversions", n_conv, 10);
    chk_eq("R10", "middle end", last_acq, s + 26);
    chk_eq("R10", "middle window", int'(buf_scans), 2);
  endtask

  task automatic t_stop();
    int c, tc;
    set_cfg(0, 10, 3, 3, 2, 5, 1, 0, 0);
    clr_mon();
    do_start(c);
    tc = c + 3;
    trig_in(tc);
    stop_in(tc + 5);
    repeat (20) @(negedge clk);
    chk_eq("R11", "conversions before stop", n_conv, 2);
    chk_eq("R11", "last busy cycle", last_acq, tc + 5);
    chk_eq("R11", "scan_busy after stop", int'(scan_busy), 0);
  endtask

  initial begin
    t_reset();
    t_cfg();
    t_post();
    t_retrig();
    t_delay();
    t_pre_late();
    t_pre_early();
    t_menable();
    t_mid();
    t_stop();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    summary();
  end
endmodule